// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns decoded stereo sample pairs into a three-wire serial audio stream: a bit clock, a left/right word clock and a data line. All of its timing comes from a 256fs clock that it builds itself from a strobe marking every edge of the system clock. The system clock runs at either 384fs or 512fs. A mode pin selects which, and so sets the duty cycle of the 256fs clock. The bit clock runs at 64fs, so each half of the word clock carries 32 bit slots.

Sample pairs arrive on a valid/ready stream. One pair is held in a single staging register. At the start of each frame (the rising edge of the word clock) the block moves the staged pair, the format select and the mute input into the serializer. The left word goes out while the word clock is high and the right word while it is low. If no pair is staged at a frame start, the frame carries zeros. Back-pressure rule: the source may present a pair at any time. The pair is taken on a cycle where valid and ready are both high. Ready then stays low until the next frame start frees the staging register, so at most one pair is taken per frame.

Two word layouts are offered: 16 bits sent MSB first, and 20 bits sent LSB first. Unused slots in each half are driven low.

Top module: `aud_serial_fmt`

## Requirements
- R1: `fs256_o` advances one phase per system-clock edge strobe. With `clk512_i` high a period is 4 strobes, high for 2 and low for 2. With `clk512_i` low a period is 3 strobes, high for 2 and low for 1.
- R2: `bclk_o`, `lrck_o` and `sdata_o` change only in the clock cycle in which `fs256_o` rises.
- R3: `bclk_o` is high for 2 and low for 2 consecutive 256fs periods (64fs).
- R4: `lrck_o` is high for the left word and low for the right word. Each half holds exactly 32 `bclk_o` cycles, and `lrck_o` toggles only together with a falling `bclk_o`.
- R5: `sdata_o` changes only together with a falling `bclk_o`. A receiver samples it on the rising `bclk_o`. Slot 0 of each half begins at the `lrck_o` edge.
- R6: With `fmt_lsb20_i` low, slots 0..15 of a half carry sample bits 19 down to 4, and slots 16..31 are low.
- R7: With `fmt_lsb20_i` high, slots 0..19 of a half carry sample bits 0 up to 19, and slots 20..31 are low.
- R8: The sample pair, `fmt_lsb20_i` and `mute_i` are taken only at a frame start, which is the rising `lrck_o`. The right half sends the right word of the same pair. Changes to the inputs after that have no effect on the frame in progress.
- R9: `smp_ready_o` is high exactly when the staging register is empty. After a pair is accepted, it stays low until the next frame start.
- R10: If no pair is staged at a frame start, both halves of that frame are all zero.
- R11: If `mute_i` is high at a frame start, the frame is all zero and the staged pair is consumed and discarded, while `bclk_o` and `lrck_o` keep running.
- R12: While `rst_n` is low: `fs256_o`=0, `bclk_o`=1, `lrck_o`=0, `sdata_o`=0 and `smp_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_edge_i | input | 1 | One-cycle strobe per system-clock edge |
| clk512_i | input | 1 | System clock mode: 1 = 512fs, 0 = 384fs |
| fmt_lsb20_i | input | 1 | Word layout: 0 = 16-bit MSB first, 1 = 20-bit LSB first |
| mute_i | input | 1 | Send zero samples |
| smp_valid_i | input | 1 | Sample pair valid |
| smp_ready_o | output | 1 | Staging register free |
| smp_left_i | input | SMP_W | Left sample |
| smp_right_i | input | SMP_W | Right sample |
| fs256_o | output | 1 | 256fs clock |
| bclk_o | output | 1 | Bit clock, 64fs |
| lrck_o | output | 1 | Word clock, high = left |
| sdata_o | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: 20-bit samples, a 16-bit narrow word, 32 slots per half and four 256fs periods per bit clock. With these values both word layouts and their zero-padded tail slots are exercised. The bench drives the system-clock mode pin both ways within one run, so the 3-phase and 4-phase 256fs periods are both covered under live frames. It also reaches the staging corner cases: a pair held off by back-pressure, a muted pair that is dropped, and a frame with no pair staged.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

  // Word layout inside one word-clock half.
  typedef enum logic {
    FMT_MSB_NARROW = 1'b0,
    FMT_LSB_WIDE   = 1'b1
  } fmt_e;

  // System clock ratio against the frame rate.
  typedef enum logic {
    SYS_384 = 1'b0,
    SYS_512 = 1'b1
  } sysclk_e;

endpackage

// File: rtl/aud_fs256_gen.sv
module aud_fs256_gen
  import aud_fmt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_stb_i,
  input  logic mode512_i,
  output logic fs256_o,
  output logic rise_o
);

  localparam int unsigned PH_W       = 2;
  localparam logic [PH_W-1:0] LAST_512 = PH_W'(3);
  localparam logic [PH_W-1:0] LAST_384 = PH_W'(2);
  localparam logic [PH_W-1:0] HIGH_PH  = PH_W'(2);

  sysclk_e         mode;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_n;
  logic [PH_W-1:0] last;
  logic            fs_q;

  assign mode = sysclk_e'(mode512_i);
  assign last = (mode == SYS_512) ? LAST_512 : LAST_384;
  assign ph_n = (ph_q >= last) ? '0 : ph_q + 1'b1;

  // Combinational: the serializer registers on the same edge as fs_q rises.
  assign rise_o  = edge_stb_i && (ph_n == '0);
  assign fs256_o = fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= LAST_512;
      fs_q <= 1'b0;
    end else if (edge_stb_i) begin
      ph_q <= ph_n;
      fs_q <= (ph_n < HIGH_PH);
    end
  end

  // R1: in 384fs mode the low phase lasts a single strobe
  a_r1_single_low_384: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb_i && !mode512_i && !fs_q) |=> fs_q);

  // R1: fs256 never moves without a strobe
  a_r1_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_stb_i) |=> $stable(fs_q));

endmodule

// File: rtl/aud_pair_stage.sv
module aud_pair_stage #(
  parameter int unsigned SMP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [SMP_W-1:0] in_left_i,
  input  logic [SMP_W-1:0] in_right_i,
  input  logic             take_i,
  output logic             have_o,
  output logic [SMP_W-1:0] out_left_o,
  output logic [SMP_W-1:0] out_right_o
);

  logic             full_q;
  logic [SMP_W-1:0] left_q;
  logic [SMP_W-1:0] right_q;

  assign in_ready_o  = !full_q;
  assign have_o      = full_q;
  assign out_left_o  = left_q;
  assign out_right_o = right_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (in_valid_i && !full_q) begin
      full_q  <= 1'b1;
      left_q  <= in_left_i;
      right_q <= in_right_i;
    end else if (take_i) begin
      full_q  <= 1'b0;
    end
  end

  // R9: an accepted pair closes the stage for at least the next cycle
  a_r9_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R9: only a frame start reopens a full stage
  a_r9_reopen_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready_o && !take_i) |=> !in_ready_o);

endmodule

// File: rtl/aud_ser_core.sv
module aud_ser_core
  import aud_fmt_pkg::*;
#(
  parameter int unsigned SMP_W   = 20,
  parameter int unsigned NAR_W   = 16,
  parameter int unsigned SLOT_LG = 5,
  parameter int unsigned DIV_LG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             fmt_i,
  input  logic             mute_i,
  input  logic             have_i,
  input  logic [SMP_W-1:0] left_i,
  input  logic [SMP_W-1:0] right_i,
  output logic             take_o,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             sdata_o
);

  localparam int unsigned POS_W = 1 + SLOT_LG + DIV_LG;
  localparam int unsigned SLOTS = 1 << SLOT_LG;

  logic [POS_W-1:0]   pos_q;
  logic [POS_W-1:0]   pos_n;
  logic               frame_start;
  logic               slot_start;
  logic               half_right;
  logic [SLOT_LG-1:0] slot;
  logic [SMP_W-1:0]   cur_l_q;
  logic [SMP_W-1:0]   cur_r_q;
  fmt_e               cur_fmt_q;
  fmt_e               fmt_n;
  logic [SMP_W-1:0]   load_l;
  logic [SMP_W-1:0]   load_r;
  logic [SMP_W-1:0]   word_n;
  logic [SLOTS-1:0]   msb_lane;
  logic [SLOTS-1:0]   lsb_lane;
  logic               bit_n;
  logic               bclk_q;
  logic               lrck_q;
  logic               sdata_q;

  assign pos_n       = pos_q + 1'b1;
  assign frame_start = tick_i && (pos_n == '0);
  assign slot_start  = tick_i && (pos_n[DIV_LG-1:0] == '0);
  assign half_right  = pos_n[POS_W-1];
  assign slot        = pos_n[DIV_LG +: SLOT_LG];
  assign take_o      = frame_start;

  assign load_l = (have_i && !mute_i) ? left_i  : '0;
  assign load_r = (have_i && !mute_i) ? right_i : '0;
  assign fmt_n  = frame_start ? fmt_e'(fmt_i) : cur_fmt_q;

  always_comb begin
    if (frame_start) word_n = half_right ? load_r : load_l;
    else             word_n = half_right ? cur_r_q : cur_l_q;
  end

  // Per-slot bit lanes for both layouts; padding slots are tied low.
  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    if (k < NAR_W) begin : g_msb
      assign msb_lane[k] = word_n[SMP_W-1-k];
    end else begin : g_msb_pad
      assign msb_lane[k] = 1'b0;
    end
    if (k < SMP_W) begin : g_lsb
      assign lsb_lane[k] = word_n[k];
    end else begin : g_lsb_pad
      assign lsb_lane[k] = 1'b0;
    end
  end

  assign bit_n = (fmt_n == FMT_LSB_WIDE) ? lsb_lane[slot] : msb_lane[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '1;
      bclk_q    <= 1'b1;
      lrck_q    <= 1'b0;
      sdata_q   <= 1'b0;
      cur_l_q   <= '0;
      cur_r_q   <= '0;
      cur_fmt_q <= FMT_MSB_NARROW;
    end else if (tick_i) begin
      pos_q  <= pos_n;
      bclk_q <= pos_n[DIV_LG-1];
      lrck_q <= ~pos_n[POS_W-1];
      if (slot_start) sdata_q <= bit_n;
      if (frame_start) begin
        cur_l_q   <= load_l;
        cur_r_q   <= load_r;
        cur_fmt_q <= fmt_e'(fmt_i);
      end
    end
  end

  assign bclk_o  = bclk_q;
  assign lrck_o  = lrck_q;
  assign sdata_o = sdata_q;

  // R4: word clock moves only with a falling bit clock
  a_r4_lrck_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(lrck_q) |-> $fell(bclk_q));

  // R5: data moves only with a falling bit clock
  a_r5_data_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sdata_q) |-> $fell(bclk_q));

  // R8: a frame start is always the left half beginning
  a_r8_frame_starts_left: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (lrck_q && !bclk_q));

endmodule

// File: rtl/aud_serial_fmt.sv
module aud_serial_fmt
  import aud_fmt_pkg::*;
#(
  parameter int unsigned SMP_W   = 20,
  parameter int unsigned NAR_W   = 16,
  parameter int unsigned SLOT_LG = 5,
  parameter int unsigned DIV_LG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_edge_i,
  input  logic             clk512_i,
  input  logic             fmt_lsb20_i,
  input  logic             mute_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic [SMP_W-1:0] smp_left_i,
  input  logic [SMP_W-1:0] smp_right_i,
  output logic             fs256_o,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             sdata_o
);

  logic             tick;
  logic             take;
  logic             have;
  logic [SMP_W-1:0] stg_l;
  logic [SMP_W-1:0] stg_r;

  aud_fs256_gen u_fs (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_stb_i (sys_edge_i),
    .mode512_i  (clk512_i),
    .fs256_o    (fs256_o),
    .rise_o     (tick)
  );

  aud_pair_stage #(.SMP_W(SMP_W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (smp_valid_i),
    .in_ready_o  (smp_ready_o),
    .in_left_i   (smp_left_i),
    .in_right_i  (smp_right_i),
    .take_i      (take),
    .have_o      (have),
    .out_left_o  (stg_l),
    .out_right_o (stg_r)
  );

  aud_ser_core #(
    .SMP_W   (SMP_W),
    .NAR_W   (NAR_W),
    .SLOT_LG (SLOT_LG),
    .DIV_LG  (DIV_LG)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .fmt_i   (fmt_lsb20_i),
    .mute_i  (mute_i),
    .have_i  (have),
    .left_i  (stg_l),
    .right_i (stg_r),
    .take_o  (take),
    .bclk_o  (bclk_o),
    .lrck_o  (lrck_o),
    .sdata_o (sdata_o)
  );

  // R2: serial outputs move only when the 256fs clock rises
  a_r2_outputs_on_fs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable({bclk_o, lrck_o, sdata_o})) |-> $rose(fs256_o));

endmodule

// File: tb/aud_serial_fmt_tb_top.sv
module aud_serial_fmt_tb_top;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_edge = 1'b0;
  logic clk512 = 1'b1;
  logic fmt = 1'b0;
  logic mute = 1'b0;
  logic valid = 1'b0;
  logic [19:0] sl = '0;
  logic [19:0] sr = '0;
  logic ready, fs, bclk, lrck, sd;

  aud_serial_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .sys_edge_i(sys_edge), .clk512_i(clk512),
    .fmt_lsb20_i(fmt), .mute_i(mute), .smp_valid_i(valid), .smp_ready_o(ready),
    .smp_left_i(sl), .smp_right_i(sr), .fs256_o(fs), .bclk_o(bclk),
    .lrck_o(lrck), .sdata_o(sd)
  );

  always #(CLK_P/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    sys_edge = ~sys_edge;
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic p_bclk = 1'b0, p_lrck = 1'b0, p_fs = 1'b0, rdy_prev = 1'b0;
  logic [19:0] e_l = '0, e_r = '0;
  logic e_fmt = 1'b0;
  bit e_zero = 1'b1, e_mute = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    p_bclk = bclk; p_lrck = lrck; p_fs = fs;
    @(negedge clk);
  endtask

  // Expected slot contents of one half (bit k = slot k)
  function automatic logic [31:0] exp_half(logic [19:0] w, logic f, bit z);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) begin
      if (z) v[k] = 1'b0;
      else if (!f) v[k] = (k < 16) ? w[19-k] : 1'b0;
      else v[k] = (k < 20) ? w[k] : 1'b0;
    end
    return v;
  endfunction

  task automatic sync_frame();
    do step(); while (!(!p_lrck && lrck));
  endtask

  // Called just after a rising lrck: offers the next pair, decodes the current frame.
  task automatic do_frame(input logic [19:0] nl, input logic [19:0] nr,
                          input logic nfmt, input logic nmute, input bit noffer, input bit bp);
    logic [31:0] gl = '0, gr = '0, xl, xr;
    int nlb = 0, nrb = 0, bp_left = 0;
    bit acc = 1'b0, bp_ok = 1'b1;
    string tg;
    fmt = nfmt; mute = nmute;
    if (noffer) begin sl = nl; sr = nr; valid = 1'b1; end
    rdy_prev = ready;
    forever begin
      step();
      if (valid && rdy_prev && !acc) begin
        acc = 1'b1; valid = 1'b0;
        sl = 20'($urandom); sr = 20'($urandom);   // R8: later input changes ignored
        if (bp) begin valid = 1'b1; bp_left = 16; end
      end else if (bp_left > 0) begin
        if (ready) bp_ok = 1'b0;
        bp_left--;
        if (bp_left == 0) valid = 1'b0;
      end
      rdy_prev = ready;
      if (!p_bclk && bclk) begin
        if (lrck) begin if (nlb < 32) gl[nlb] = sd; nlb++; end
        else      begin if (nrb < 32) gr[nrb] = sd; nrb++; end
      end
      if (!p_lrck && lrck) break;
    end
    check(nlb == 32 && nrb == 32, "R4 bclk cycles per lrck half", {32'(nlb), 32'(nrb)}, {32'd32, 32'd32});
    xl = exp_half(e_l, e_fmt, e_zero);
    xr = exp_half(e_r, e_fmt, e_zero);
    if (e_zero) tg = e_mute ? "R11 muted frame" : "R10 idle frame";
    else tg = e_fmt ? "R7 lsb-first R8 pair" : "R6 msb-first R8 pair";
    check(gl == xl, {tg, " left"}, 64'(gl), 64'(xl));
    check(gr == xr, {tg, " right"}, 64'(gr), 64'(xr));
    check(acc == noffer, "R9 pair accepted once per frame", 64'(acc), 64'(noffer));
    if (bp) check(bp_ok, "R9 ready low while staging full", 64'(bp_ok), 64'd1);
    e_l = nl; e_r = nr; e_fmt = nfmt; e_mute = nmute;
    e_zero = !noffer || nmute;
  endtask

  task automatic check_fs(input logic mode);
    int hi = 0;
    clk512 = mode;
    repeat (8) step();
    repeat (24) begin step(); if (fs) hi++; end
    check(hi == (mode ? 12 : 16), mode ? "R1 512fs duty" : "R1 384fs duty", 64'(hi), mode ? 64'd12 : 64'd16);
  endtask

  task automatic check_bclk();
    int c = 0;
    do step(); while (!(!p_bclk && bclk));
    do begin step(); if (!p_fs && fs) c++; end while (!(p_bclk && !bclk));
    check(c == 2, "R3 bclk high span", 64'(c), 64'd2);
    c = 0;
    do begin step(); if (!p_fs && fs) c++; end while (!(!p_bclk && bclk));
    check(c == 2, "R3 bclk low span", 64'(c), 64'd2);
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (4) step();
    // R12 reset state
    check(fs == 1'b0, "R12 fs256 reset", 64'(fs), 64'd0);
    check(bclk == 1'b1, "R12 bclk reset", 64'(bclk), 64'd1);
    check(lrck == 1'b0, "R12 lrck reset", 64'(lrck), 64'd0);
    check(sd == 1'b0, "R12 sdata reset", 64'(sd), 64'd0);
    check(ready == 1'b1, "R12 ready reset", 64'(ready), 64'd1);
    rst_n = 1'b1;

    check_fs(1'b1);
    check_bclk();
    sync_frame();
    e_zero = 1'b1; e_mute = 1'b0;
    do_frame(20'hFFFFF, 20'hFFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    do_frame(20'hFFFFF, 20'h00001, 1'b1, 1'b0, 1'b1, 1'b0);
    do_frame(20'hA5A5A, 20'h5A5A5, 1'b0, 1'b0, 1'b1, 1'b1);
    do_frame(20'h12345, 20'hFEDCB, 1'b1, 1'b1, 1'b1, 1'b0);   // R11 mute drops the pair
    do_frame(20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);           // R10 nothing staged
    do_frame(20'h80001, 20'h7FFFE, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 14; i++)
      do_frame(20'($urandom), 20'($urandom), 1'($urandom % 2),
               ($urandom % 8) == 0, ($urandom % 6) != 0, 1'b0);
    do_frame(20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    check_fs(1'b0);
    check_bclk();
    sync_frame();
    e_zero = 1'b1; e_mute = 1'b0;
    do_frame(20'h0000F, 20'hF0000, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++)
      do_frame(20'($urandom), 20'($urandom), 1'($urandom % 2),
               ($urandom % 8) == 0, ($urandom % 6) != 0, 1'b0);
    do_frame(20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog actual=hung expected=frames complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule